// File: doc/BRIEF.md
# Software Store/Recall Sequence Controller

This block sits in front of a small byte-wide SRAM array that has a shadow nonvolatile copy, and lets software move data between the two without dedicated pins. It watches read accesses, each started by a falling chip enable, for a fixed series of six 13-bit addresses. Five address keys are common to both commands. The sixth key chooses between a store (SRAM to shadow) and a recall (shadow to SRAM). Any write access, or any address that does not match, breaks the series. The controller then holds busy and blocks normal accesses for the whole timed operation.

After reset the controller runs a power-up recall, so the SRAM starts with the shadow contents. A store request made while the power-good flag is low is discarded. Durations are counted in clock cycles and set by parameters. The arrays are register models, indexed by the low `MEM_AW` address bits.

States: `ST_BOOT_RCL` (power-up recall), `ST_IDLE` (normal access and matching), `ST_STORE`, `ST_RECALL`. Transitions: reset → `ST_BOOT_RCL`; `ST_BOOT_RCL` → `ST_IDLE` when its timer expires; `ST_IDLE` → `ST_STORE` on a store hit with power good; `ST_IDLE` → `ST_RECALL` on a recall hit; `ST_STORE` and `ST_RECALL` → `ST_IDLE` when their timers expire.

Top module: `swsr_ctrl`

## Requirements
- R1: During reset, and for exactly BOOT_CYC cycles after reset is released, busy and inhibit are high and no strobe fires. When this ends, every SRAM location holds its shadow value.
- R2: An access event is a clock cycle in which ce_n is low after being high in the previous cycle. we_n high makes it a read and we_n low makes it a write. Holding ce_n low yields one event, however long it is held and however the address changes.
- R3: In idle, six read events with addresses 13'h1A5C, 13'h05A3, 13'h1F00, 13'h00FF, 13'h1234 and then 13'h0DB6, while pwr_ok is high, raise store_go for one cycle. store_go is seen in the cycle after the clock edge that samples the sixth event, and busy rises together with it.
- R4: The same five keys followed by 13'h1249 raise recall_go for one cycle with the same timing. Busy then lasts RECALL_CYC cycles, and at its end the SRAM equals the shadow copy.
- R5: A store keeps busy high for exactly STORE_CYC cycles. The shadow copy takes the SRAM contents present when the store starts.
- R6: A write event in the middle of a series sends matching back to the first key.
- R7: A read whose address is not the expected key sends matching back to the first key. If that address is the first key, the next expected key is the second one.
- R8: The level of oe_n has no effect on matching, strobes, busy or inhibit.
- R9: A store hit while pwr_ok is low produces no strobe and no busy, clears the series and leaves the shadow copy unchanged.
- R10: While busy, access events are ignored: writes leave the SRAM unchanged, reads leave dout unchanged, and addresses do not advance the matcher.
- R11: In idle, a write event stores din at location addr[MEM_AW-1:0]. A read event loads that location into dout, visible after the sampling edge. dout reads zero while oe_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 13 | Access address |
| ce_n | input | 1 | Active-low chip enable; a falling level starts an access |
| we_n | input | 1 | Active-low write enable, sampled at the access event |
| oe_n | input | 1 | Active-low output enable for dout only |
| pwr_ok | input | 1 | Supply above the store threshold |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero while oe_n is high |
| busy | output | 1 | Timed recall or store in progress |
| store_go | output | 1 | One-cycle pulse when a store starts |
| recall_go | output | 1 | One-cycle pulse when a software recall starts |
| inhibit | output | 1 | Normal accesses are blocked |

## Verification
Full series are sent with both final keys. This shows that the common prefix is shared and that only the last key picks the operation. Broken series are also sent: with a write in the middle, with a stray address, and with a repeated first key. These show the difference between a reset to step one and a re-arm at step two. A chip enable held low across two addresses shows that matching is edge-driven and not level-driven. A series sent with oe_n high and one sent with pwr_ok low show which inputs gate the launch. Data patterns written before a store, overwritten, and then recalled show the snapshot point and the restore. Writes and a whole series sent during busy show that the block ignores them.

// File: rtl/swsr_pkg.sv
package swsr_pkg;

    localparam int ADDR_W   = 13;
    localparam int N_STEPS  = 6;
    localparam int STEP_W   = $clog2(N_STEPS);

    localparam logic [ADDR_W-1:0] KEY_STORE  = 13'h0DB6;
    localparam logic [ADDR_W-1:0] KEY_RECALL = 13'h1249;

    typedef enum logic [1:0] {
        ST_BOOT_RCL,
        ST_IDLE,
        ST_STORE,
        ST_RECALL
    } ctl_state_t;

    // shared prefix keys, position 0 .. N_STEPS-2
    function automatic logic [ADDR_W-1:0] prefix_key(input logic [STEP_W-1:0] pos);
        logic [ADDR_W-1:0] k;
        case (pos)
            3'd0:    k = 13'h1A5C;
            3'd1:    k = 13'h05A3;
            3'd2:    k = 13'h1F00;
            3'd3:    k = 13'h00FF;
            default: k = 13'h1234;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/swsr_matcher.sv
module swsr_matcher
    import swsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rd_ev,
    input  logic              wr_ev,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_store,
    output logic              hit_recall
);

    localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

    logic [STEP_W-1:0] step_q, step_d;
    logic              at_last, is_first;

    assign at_last  = (step_q == LAST);
    assign is_first = (addr == prefix_key('0));

    always_comb begin
        hit_store  = rd_ev && at_last && (addr == KEY_STORE);
        hit_recall = rd_ev && at_last && (addr == KEY_RECALL);
        step_d     = step_q;
        if (clr || wr_ev) begin
            step_d = '0;
        end else if (rd_ev) begin
            if (!at_last && (addr == prefix_key(step_q))) begin
                step_d = step_q + 1'b1;
            end else if (is_first) begin
                step_d = STEP_W'(1);
            end else begin
                step_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else begin
            step_q <= step_d;
        end
    end

endmodule

// File: rtl/swsr_timer.sv
module swsr_timer #(
    parameter int CNT_W = 8,
    parameter int INIT  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(INIT);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/swsr_mem.sv
module swsr_mem #(
    parameter int MEM_AW = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              snap,
    input  logic              restore,
    input  logic [MEM_AW-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_q
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] sram_q [DEPTH];
    logic [DATA_W-1:0] nv_q   [DEPTH];

    // working array: restore wins over a single write
    always_ff @(posedge clk) begin
        if (restore) begin
            for (int i = 0; i < DEPTH; i++) begin
                sram_q[i] <= nv_q[i];
            end
        end else if (wr_en) begin
            sram_q[addr] <= din;
        end
    end

    // shadow array keeps its contents through reset
    always_ff @(posedge clk) begin
        if (snap) begin
            for (int i = 0; i < DEPTH; i++) begin
                nv_q[i] <= sram_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= sram_q[addr];
        end
    end

endmodule

// File: rtl/swsr_ctrl.sv
module swsr_ctrl
    import swsr_pkg::*;
#(
    parameter int MEM_AW     = 4,
    parameter int DATA_W     = 8,
    parameter int BOOT_CYC   = 68750,
    parameter int STORE_CYC  = 1250000,
    parameter int RECALL_CYC = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              pwr_ok,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              busy,
    output logic              store_go,
    output logic              recall_go,
    output logic              inhibit
);

    localparam int MAX_A   = (BOOT_CYC > STORE_CYC) ? BOOT_CYC : STORE_CYC;
    localparam int MAX_CYC = (MAX_A > RECALL_CYC) ? MAX_A : RECALL_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    ctl_state_t        state_q, state_d;
    logic              ce_q, acc_ev, idle, rd_ev, wr_ev;
    logic              hit_store, hit_recall;
    logic              tmr_load, tmr_done, snap, restore;
    logic [CNT_W-1:0]  tmr_val;
    logic [DATA_W-1:0] rd_q;

    // access event: falling chip enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q <= 1'b1;
        end else begin
            ce_q <= ce_n;
        end
    end

    assign idle   = (state_q == ST_IDLE);
    assign acc_ev = ce_q && !ce_n;
    assign rd_ev  = acc_ev && we_n && idle;
    assign wr_ev  = acc_ev && !we_n && idle;

    swsr_matcher u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (!idle),
        .rd_ev      (rd_ev),
        .wr_ev      (wr_ev),
        .addr       (addr),
        .hit_store  (hit_store),
        .hit_recall (hit_recall)
    );

    swsr_timer #(.CNT_W(CNT_W), .INIT(BOOT_CYC - 1)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // next state and timer launch
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_BOOT_RCL: if (tmr_done) state_d = ST_IDLE;
            ST_IDLE: begin
                if (hit_store && pwr_ok) begin
                    state_d  = ST_STORE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(STORE_CYC - 1);
                end else if (hit_recall) begin
                    state_d  = ST_RECALL;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(RECALL_CYC - 1);
                end
            end
            ST_STORE:    if (tmr_done) state_d = ST_IDLE;
            ST_RECALL:   if (tmr_done) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    assign snap    = idle && (state_d == ST_STORE);
    assign restore = ((state_q == ST_BOOT_RCL) || (state_q == ST_RECALL)) && tmr_done;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOOT_RCL;
        end else begin
            state_q <= state_d;
        end
    end

    // registered strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_go  <= 1'b0;
            recall_go <= 1'b0;
        end else begin
            store_go  <= snap;
            recall_go <= idle && (state_d == ST_RECALL);
        end
    end

    always_comb begin
        busy    = !idle;
        inhibit = (state_q != ST_IDLE);
        dout    = oe_n ? '0 : rd_q;
    end

    swsr_mem #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ev),
        .rd_en   (rd_ev),
        .snap    (snap),
        .restore (restore),
        .addr    (addr[MEM_AW-1:0]),
        .din     (din),
        .rd_q    (rd_q)
    );

endmodule

// File: rtl/swsr_chk.sv
module swsr_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          we_n,
    input logic          oe_n,
    input logic          pwr_ok,
    input logic [DW-1:0] dout,
    input logic          busy,
    input logic          store_go,
    input logic          recall_go
);

    // R3
    store_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_go |-> (busy && !$past(busy)));

    // R4
    recall_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recall_go |-> (busy && !$past(busy)));

    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_go, recall_go}));

    // R9
    low_power_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_go |-> $past(pwr_ok));

    // R2
    store_after_read_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_go |-> ($past(!ce_n) && $past(we_n) && $past(ce_n, 2)));

    // R10
    busy_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !oe_n && !$past(oe_n)) |-> $stable(dout));

endmodule

bind swsr_ctrl swsr_chk #(.DW(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .pwr_ok    (pwr_ok),
    .dout      (dout),
    .busy      (busy),
    .store_go  (store_go),
    .recall_go (recall_go)
);

// File: tb/swsr_ctrl_tb_top.sv
module swsr_ctrl_tb_top;

    localparam int MAW   = 4;
    localparam int DEPTH = 16;
    localparam int BOOT  = 20;
    localparam int STOR  = 40;
    localparam int RCL   = 12;

    localparam logic [12:0] K0 = 13'h1A5C, K1 = 13'h05A3, K2 = 13'h1F00,
                            K3 = 13'h00FF, K4 = 13'h1234;
    localparam logic [12:0] KST = 13'h0DB6, KRC = 13'h1249;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] addr = '0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b0, pwr_ok = 1'b1;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        busy, store_go, recall_go, inhibit;

    always #4 clk = ~clk;

    swsr_ctrl #(.MEM_AW(MAW), .DATA_W(8), .BOOT_CYC(BOOT), .STORE_CYC(STOR),
                .RECALL_CYC(RCL)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .pwr_ok(pwr_ok), .din(din), .dout(dout), .busy(busy),
        .store_go(store_go), .recall_go(recall_go), .inhibit(inhibit)
    );

    int checks = 0, errors = 0, n_store = 0, n_recall = 0;
    bit ended = 1'b0;

    // ---------------- behavioural reference ----------------
    int         m_state;  // 0 boot, 1 idle, 2 store, 3 recall
    int         m_cnt, m_step;
    bit         m_ceq;
    bit         m_sgo, m_rgo;
    logic [7:0] m_rd;
    logic [7:0] m_sram [DEPTH];
    logic [7:0] m_nv   [DEPTH];
    logic [12:0] series_q [$] = '{K0, K1, K2, K3, K4};

    always @(posedge clk) begin
        bit ev, rd, wr;
        int a;
        if (!rst_n) begin
            m_state = 0; m_cnt = BOOT - 1; m_step = 0; m_ceq = 1'b1;
            m_sgo = 1'b0; m_rgo = 1'b0; m_rd = '0;
        end else begin
            ev = m_ceq && !ce_n;
            rd = ev && we_n;
            wr = ev && !we_n;
            a  = int'(addr[MAW-1:0]);
            m_sgo = 1'b0;
            m_rgo = 1'b0;
            if (m_state == 1) begin
                if (wr) begin
                    m_sram[a] = din;
                    m_step = 0;
                end
                if (rd) begin
                    m_rd = m_sram[a];
                    if (m_step == 5) begin
                        if (addr == KST && pwr_ok) begin
                            m_state = 2; m_cnt = STOR - 1; m_sgo = 1'b1;
                            for (int i = 0; i < DEPTH; i++) m_nv[i] = m_sram[i];
                        end else if (addr == KRC) begin
                            m_state = 3; m_cnt = RCL - 1; m_rgo = 1'b1;
                        end
                        m_step = (addr == K0) ? 1 : 0;
                    end else if (addr == series_q[m_step]) begin
                        m_step++;
                    end else begin
                        m_step = (addr == K0) ? 1 : 0;
                    end
                end
            end else begin
                m_step = 0;
                if (m_cnt == 0) begin
                    if (m_state != 2)
                        for (int i = 0; i < DEPTH; i++) m_sram[i] = m_nv[i];
                    m_state = 1;
                end else begin
                    m_cnt--;
                end
            end
            m_ceq = ce_n;
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        logic [7:0] exp_d;
        #2;
        if (rst_n && !ended) begin
            exp_d = oe_n ? 8'h00 : m_rd;
            checks++;
            if (busy !== (m_state != 1)) begin
                errors++; $display("FAIL R5 busy act=%0b exp=%0b", busy, m_state != 1);
            end
            if (inhibit !== (m_state != 1)) begin
                errors++; $display("FAIL R1 inhibit act=%0b exp=%0b", inhibit, m_state != 1);
            end
            if (store_go !== m_sgo) begin
                errors++; $display("FAIL R3 store_go act=%0b exp=%0b", store_go, m_sgo);
            end
            if (recall_go !== m_rgo) begin
                errors++; $display("FAIL R4 recall_go act=%0b exp=%0b", recall_go, m_rgo);
            end
            if (!$isunknown(exp_d) && dout !== exp_d) begin
                errors++; $display("FAIL R11 dout act=%0h exp=%0h", dout, exp_d);
            end
            if (store_go === 1'b1)  n_store++;
            if (recall_go === 1'b1) n_recall++;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up;
        if (!ended) begin
            ended = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic acc_start(input logic [12:0] a, input bit wr, input logic [7:0] d);
        addr = a; we_n = !wr; din = d; ce_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic acc(input logic [12:0] a, input bit wr, input logic [7:0] d);
        acc_start(a, wr, d);
        @(negedge clk);
    endtask

    task automatic send_series(input logic [12:0] last);
        foreach (series_q[i]) acc(series_q[i], 1'b0, 8'h00);
        acc_start(last, 1'b0, 8'h00);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy === 1'b1 && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic rd_chk(input logic [12:0] a, input logic [7:0] exp, input string req);
        acc_start(a, 1'b0, 8'h00);
        chk(dout === exp, req, int'(dout), int'(exp));
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=0 exp=1");
        finish_up();
    end

    // ---------------- directed sequence ----------------
    initial begin
        int n;
        int s0, r0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy === 1'b1 && inhibit === 1'b1 && store_go === 1'b0 && recall_go === 1'b0,
            "R1 reset outputs", int'(busy), 1);
        rst_n = 1'b1;
        count_busy(n);
        chk(n == BOOT, "R1 power-up recall length", n, BOOT);
        @(negedge clk);

        // R11 fill pattern A and read back
        for (int i = 0; i < DEPTH; i++) acc(13'(i), 1'b1, 8'h30 + 8'(i));
        rd_chk(13'd4, 8'h34, "R11 read after write");
        rd_chk(13'd15, 8'h3F, "R11 read last location");

        // R3 / R5 store
        send_series(KST);
        chk(store_go === 1'b1, "R3 store strobe", int'(store_go), 1);
        count_busy(n);
        chk(n == STOR, "R5 store length", n, STOR);
        @(negedge clk);

        // corrupt with pattern B
        for (int i = 0; i < DEPTH; i++) acc(13'(i), 1'b1, 8'hA0 + 8'(i));
        rd_chk(13'd3, 8'hA3, "R11 corrupted value");

        // R4 recall restores pattern A
        send_series(KRC);
        chk(recall_go === 1'b1, "R4 recall strobe", int'(recall_go), 1);
        count_busy(n);
        chk(n == RCL, "R4 recall length", n, RCL);
        @(negedge clk);
        rd_chk(13'd0, 8'h30, "R4 restored loc0");
        rd_chk(13'd9, 8'h39, "R4 restored loc9");

        // R6 write mid-series aborts
        s0 = n_store;
        acc(K0, 1'b0, 8'h00); acc(K1, 1'b0, 8'h00); acc(K2, 1'b0, 8'h00);
        acc(13'd7, 1'b1, 8'h55);
        acc(K3, 1'b0, 8'h00); acc(K4, 1'b0, 8'h00);
        acc_start(KST, 1'b0, 8'h00);
        chk(store_go === 1'b0 && busy === 1'b0, "R6 write aborts series", int'(busy), 0);
        @(negedge clk);
        chk(n_store == s0, "R6 no store launched", n_store, s0);

        // R7 stray address aborts
        acc(K0, 1'b0, 8'h00); acc(K1, 1'b0, 8'h00); acc(13'h0ABC, 1'b0, 8'h00);
        acc(K2, 1'b0, 8'h00); acc(K3, 1'b0, 8'h00); acc(K4, 1'b0, 8'h00);
        acc_start(KRC, 1'b0, 8'h00);
        chk(recall_go === 1'b0 && busy === 1'b0, "R7 stray address aborts", int'(recall_go), 0);
        @(negedge clk);

        // R7 first key re-arms at step two
        acc(K0, 1'b0, 8'h00); acc(K1, 1'b0, 8'h00);
        send_series(KRC);
        chk(recall_go === 1'b1, "R7 re-arm on first key", int'(recall_go), 1);
        count_busy(n);
        @(negedge clk);
        rd_chk(13'd7, 8'h37, "R4 loc7 restored after abort write");

        // R8 oe_n high does not matter
        oe_n = 1'b1;
        send_series(KRC);
        chk(recall_go === 1'b1, "R8 series with oe_n high", int'(recall_go), 1);
        chk(dout === 8'h00, "R11 dout zero while oe_n high", int'(dout), 0);
        count_busy(n);
        oe_n = 1'b0;
        @(negedge clk);

        // R2 held chip enable is one event
        addr = K0; we_n = 1'b1; ce_n = 1'b0;
        repeat (3) @(negedge clk);
        addr = K1;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        acc(K1, 1'b0, 8'h00); acc(K2, 1'b0, 8'h00); acc(K3, 1'b0, 8'h00);
        acc(K4, 1'b0, 8'h00);
        acc_start(KRC, 1'b0, 8'h00);
        chk(recall_go === 1'b1, "R2 one event per chip-enable low", int'(recall_go), 1);
        count_busy(n);
        @(negedge clk);

        // R9 low power store is dropped, shadow unchanged
        for (int i = 0; i < 4; i++) acc(13'(i), 1'b1, 8'h5A ^ 8'(i));
        pwr_ok = 1'b0;
        s0 = n_store;
        send_series(KST);
        chk(store_go === 1'b0 && busy === 1'b0, "R9 no store at low power", int'(busy), 0);
        @(negedge clk);
        chk(n_store == s0, "R9 store count unchanged", n_store, s0);
        pwr_ok = 1'b1;
        send_series(KRC);
        chk(recall_go === 1'b1, "R9 recall after dropped store", int'(recall_go), 1);
        count_busy(n);
        @(negedge clk);
        rd_chk(13'd2, 8'h32, "R9 shadow kept older data");

        // R10 accesses during busy are ignored
        acc(13'd0, 1'b1, 8'hC3);
        send_series(KST);
        chk(store_go === 1'b1, "R3 store before busy test", int'(store_go), 1);
        @(negedge clk);
        r0 = n_recall;
        acc(13'd0, 1'b1, 8'h11);
        send_series(KRC);
        @(negedge clk);
        count_busy(n);
        @(negedge clk);
        chk(n_recall == r0, "R10 series during busy ignored", n_recall, r0);
        rd_chk(13'd0, 8'hC3, "R10 write during busy ignored");

        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule